// File: doc/BRIEF.md
# Measurement channel calibration sequencer

This block calibrates one sampled measurement channel. A stream of signed Q1.15 conversion samples passes through a live correction path. That path adds a signed offset register, multiplies by an unsigned Q2.14 gain register and saturates, giving the corrected output. A start command with a mode code and a cycle count N launches one of three routines. DC offset calibration stores the negated mean of N raw samples. DC gain calibration stores the reciprocal of the mean of N corrected samples. AC gain calibration stores the constant 0.6 divided by an RMS figure, which an external RMS stage supplies with its own strobe.

Each routine first discards 30 settling conversions. It then accumulates over its window: N conversions for the DC routines and 6N for AC gain. A shared sequential divider forms the result, the result is written to its register, and done pulses for one cycle. Once written, the register acts on every later sample.

The controller moves through the states IDLE, SETTLE, ACCUM, LAUNCH, DIVIDE and FINISH:
- IDLE goes to SETTLE on an accepted start.
- SETTLE goes to ACCUM on the 30th conversion.
- ACCUM goes to LAUNCH on the last conversion of its window.
- LAUNCH always goes to DIVIDE after one cycle.
- DIVIDE goes to FINISH when the divider reports its quotient.
- FINISH always returns to IDLE after one cycle.

Top module: `cal_seq`

## Requirements
- R1: When `smp_valid_i` is high at a clock edge, `out_valid_o` is high in the following cycle, and `out_o` = sat16(floor(sat16(smp + offset) × gain / 2^14)). When `smp_valid_i` is low, `out_valid_o` is low and `out_o` holds its value. sat16 clamps to the range [-32768, 32767].
- R2: After reset, `offset_o` = 0, `gain_o` = 0x4000 (1.0), `out_o` = 0, and `out_valid_o`, `busy_o`, `done_o` and `err_o` are 0.
- R3: Mode 0 (DC offset) sums N raw input samples after settling. It writes −trunc(sum/N) to `offset_o`, truncating toward zero and clamping to 32767. `offset_o` changes only in the cycle where `done_o` is high.
- R4: An accepted start of mode 1 or mode 2 sets `gain_o` to 0x4000 in the next cycle.
- R5: Mode 1 (DC gain) sums N corrected values after settling. It writes floor(2^29·N / sum) to `gain_o`. Apart from R4, `gain_o` changes only with `done_o`.
- R6: Mode 2 (AC gain) counts 6N conversions after settling and keeps the latest `rms_i` strobed during that window. It writes floor(322122547 / rms) to `gain_o`; the constant is 0.6 in the same scaling.
- R7: In every routine, the first 30 conversions after start are discarded. A DC routine therefore spans at least N+30 conversions and AC gain at least 6N+30. `done_o` is high for exactly one cycle, 44 clock cycles after the edge that takes the final counted conversion.
- R8: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start is ignored while busy, with mode 3, or with N = 0.
- R9: In a gain routine, a zero divisor (sum ≤ 0 for DC, rms = 0 for AC) or a quotient above 0xFFFF writes `gain_o` = 0xFFFF and raises `err_o` together with `done_o`. `err_o` clears on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Conversion sample strobe |
| smp_i | input | 16 | Signed Q1.15 sample |
| ncyc_i | input | 12 | Cycle count N, captured at start |
| start_i | input | 1 | Start command |
| mode_i | input | 2 | 0 DC offset, 1 DC gain, 2 AC gain, 3 reserved |
| rms_valid_i | input | 1 | RMS value strobe |
| rms_i | input | 16 | Unsigned Q1.15 RMS value |
| out_valid_o | output | 1 | Corrected sample strobe |
| out_o | output | 16 | Corrected signed sample |
| busy_o | output | 1 | Routine in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last gain result saturated |
| offset_o | output | 16 | Offset register |
| gain_o | output | 16 | Gain register, Q2.14 |

## Verification
A wrong state or window counter shows first as `done_o` arriving in the wrong cycle. The per-clock model catches this at the exact cycle, 44 cycles after the last counted conversion. A corrupted accumulator, a wrong latched RMS value or a wrong divider operand shows at the `done_o` cycle as a wrong `offset_o` or `gain_o`. From the next valid sample onward it also shows as a wrong `out_o`. A mishandled start shows within one cycle as `busy_o` or `gain_o` differing from the model.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ACCUM,
        ST_LAUNCH,
        ST_DIVIDE,
        ST_FINISH
    } cal_state_t;

    typedef enum logic [1:0] {
        MODE_DC_OFS  = 2'd0,
        MODE_DC_GAIN = 2'd1,
        MODE_AC_GAIN = 2'd2,
        MODE_RSVD    = 2'd3
    } cal_mode_t;
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int W = 42
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CNTW = $clog2(W + 1);

    logic [W-1:0]    q_r;
    logic [W-1:0]    d_r;
    logic [W:0]      r_r;
    logic [CNTW-1:0] cnt_r;
    logic            done_r;
    logic [W:0]      shifted;
    logic            ge;

    always_comb begin
        shifted = {r_r[W-1:0], q_r[W-1]};
        ge      = (shifted >= {1'b0, d_r});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            d_r    <= '0;
            r_r    <= '0;
            cnt_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (go_i) begin
                q_r   <= num_i;
                d_r   <= den_i;
                r_r   <= '0;
                cnt_r <= CNTW'(W);
            end else if (cnt_r != '0) begin
                r_r   <= ge ? (shifted - {1'b0, d_r}) : shifted;
                q_r   <= {q_r[W-2:0], ge};
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNTW'(1)) begin
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_r;
    assign quot_o = q_r;
endmodule

// File: rtl/cal_live_path.sv
module cal_live_path #(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int GFRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic signed [DW-1:0] offset_i,
    input  logic [GW-1:0]        gain_i,
    output logic signed [DW-1:0] y_o,
    output logic                 out_valid_o,
    output logic signed [DW-1:0] out_o
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] P_MAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] P_MIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW:0]   s_wide;
    logic signed [DW-1:0] s_sat;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        s_wide = {smp_i[DW-1], smp_i} + {offset_i[DW-1], offset_i};
        if (s_wide[DW] != s_wide[DW-1]) begin
            s_sat = s_wide[DW] ? S_MIN : S_MAX;
        end else begin
            s_sat = s_wide[DW-1:0];
        end
        prod   = s_sat * $signed({1'b0, gain_i});
        scaled = prod >>> GFRAC;
        if (scaled > P_MAX) begin
            y_o = S_MAX;
        end else if (scaled < P_MIN) begin
            y_o = S_MIN;
        end else begin
            y_o = scaled[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_o       <= '0;
        end else begin
            out_valid_o <= smp_valid_i;
            if (smp_valid_i) begin
                out_o <= y_o;
            end
        end
    end
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
    parameter int DW      = 16,
    parameter int NW      = 12,
    parameter int GW      = 16,
    parameter int GFRAC   = 14,
    parameter int SETTLE  = 30,
    parameter int AC_MULT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic [NW-1:0]        ncyc_i,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic                 rms_valid_i,
    input  logic [DW-1:0]        rms_i,
    output logic                 out_valid_o,
    output logic signed [DW-1:0] out_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic signed [DW-1:0] offset_o,
    output logic [GW-1:0]        gain_o
);
    import cal_pkg::*;

    localparam int SW   = DW + NW;
    localparam int DIVW = NW + GFRAC + DW;
    localparam int CW   = NW + $clog2(AC_MULT) + 1;
    localparam int STW  = $clog2(SETTLE + 1);
    localparam int QS   = GFRAC + DW - 1;
    localparam logic [GW-1:0]   G_UNITY = GW'(1) << GFRAC;
    localparam logic [DIVW-1:0] AC_NUM  = DIVW'((64'd3 << QS) / 64'd5);
    localparam logic [DW:0]     OFS_MAX = {2'b00, {(DW-1){1'b1}}};

    cal_state_t         state_r, state_nx;
    cal_mode_t          mode_r;
    logic [NW-1:0]      ncyc_r;
    logic [STW-1:0]     scnt_r;
    logic [CW-1:0]      cnt_r;
    logic [CW-1:0]      target;
    logic signed [SW-1:0] sum_r;
    logic [DW-1:0]      rms_r;
    logic signed [DW-1:0] offset_r;
    logic [GW-1:0]      gain_r;
    logic               err_r;
    logic               start_ok;
    logic               div_go;
    logic               div_done;
    logic [DIVW-1:0]    div_num;
    logic [DIVW-1:0]    div_den;
    logic [DIVW-1:0]    div_quot;
    logic [SW-1:0]      abs_sum;
    logic               div_bad;
    logic [DW:0]        ofs_q;
    logic [DW-1:0]      ofs_new;
    logic signed [DW-1:0] live_y;

    cal_live_path #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid_i(smp_valid_i),
        .smp_i      (smp_i),
        .offset_i   (offset_r),
        .gain_i     (gain_r),
        .y_o        (live_y),
        .out_valid_o(out_valid_o),
        .out_o      (out_o)
    );

    cal_divider #(.W(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (div_num),
        .den_i (div_den),
        .done_o(div_done),
        .quot_o(div_quot)
    );

    assign start_ok = start_i && (mode_i != MODE_RSVD) && (ncyc_i != '0);
    assign target   = (mode_r == MODE_AC_GAIN) ? CW'(ncyc_r) * CW'(AC_MULT) : CW'(ncyc_r);

    always_comb begin
        abs_sum = sum_r[SW-1] ? SW'(-sum_r) : SW'(sum_r);
        unique case (mode_r)
            MODE_DC_GAIN: begin
                div_num = DIVW'(ncyc_r) << QS;
                div_den = (!sum_r[SW-1] && sum_r != '0) ? {{(DIVW-SW){1'b0}}, sum_r} : '0;
            end
            MODE_AC_GAIN: begin
                div_num = AC_NUM;
                div_den = DIVW'(rms_r);
            end
            default: begin
                div_num = DIVW'(abs_sum);
                div_den = DIVW'(ncyc_r);
            end
        endcase
        div_bad = (div_den == '0) || (|div_quot[DIVW-1:GW]);
        ofs_q   = div_quot[DW:0];
        if (sum_r[SW-1]) begin
            ofs_new = (ofs_q > OFS_MAX) ? OFS_MAX[DW-1:0] : ofs_q[DW-1:0];
        end else begin
            ofs_new = '0 - ofs_q[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
        end else begin
            state_r <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_IDLE:   if (start_ok) state_nx = ST_SETTLE;
            ST_SETTLE: if (smp_valid_i && scnt_r == STW'(SETTLE - 1)) state_nx = ST_ACCUM;
            ST_ACCUM:  if (smp_valid_i && cnt_r == target - CW'(1)) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_r != ST_IDLE);
        done_o = (state_r == ST_FINISH);
        div_go = (state_r == ST_LAUNCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r   <= MODE_DC_OFS;
            ncyc_r   <= '0;
            scnt_r   <= '0;
            cnt_r    <= '0;
            sum_r    <= '0;
            rms_r    <= '0;
            offset_r <= '0;
            gain_r   <= G_UNITY;
            err_r    <= 1'b0;
        end else begin
            unique case (state_r)
                ST_IDLE: if (start_ok) begin
                    mode_r <= cal_mode_t'(mode_i);
                    ncyc_r <= ncyc_i;
                    scnt_r <= '0;
                    cnt_r  <= '0;
                    sum_r  <= '0;
                    rms_r  <= '0;
                    err_r  <= 1'b0;
                    if (mode_i != MODE_DC_OFS) gain_r <= G_UNITY;
                end
                ST_SETTLE: if (smp_valid_i) scnt_r <= scnt_r + 1'b1;
                ST_ACCUM: begin
                    if (mode_r == MODE_AC_GAIN && rms_valid_i) rms_r <= rms_i;
                    if (smp_valid_i) begin
                        cnt_r <= cnt_r + 1'b1;
                        if (mode_r == MODE_DC_OFS) sum_r <= sum_r + SW'(smp_i);
                        else if (mode_r == MODE_DC_GAIN) sum_r <= sum_r + SW'(live_y);
                    end
                end
                ST_DIVIDE: if (div_done) begin
                    if (mode_r == MODE_DC_OFS) begin
                        offset_r <= ofs_new;
                    end else begin
                        gain_r <= div_bad ? '1 : div_quot[GW-1:0];
                        err_r  <= div_bad;
                    end
                end
                default: ;
            endcase
        end
    end

    assign offset_o = offset_r;
    assign gain_o   = gain_r;
    assign err_o    = err_r;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int GFRAC = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    mode_i,
    input logic          smp_valid_i,
    input logic          out_valid_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [DW-1:0] offset_o,
    input logic [GW-1:0] gain_o
);
    localparam logic [GW-1:0] G_UNITY = GW'(1) << GFRAC;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> out_valid_o);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> !out_valid_o);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    a_r4_gain_unity: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(mode_i) != 2'd0) |-> gain_o == G_UNITY);
    a_r3_offset_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_o) |-> done_o);
    a_r5_gain_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> (done_o || $rose(busy_o)));
    a_r9_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> gain_o == '1);
    a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !err_o);
endmodule

bind cal_seq cal_seq_chk #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .smp_valid_i(smp_valid_i),
    .out_valid_o(out_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .offset_o   (offset_o),
    .gain_o     (gain_o)
);

// File: tb/sim_cal_seq.sv
module sim_cal_seq;
    localparam int LAT = 12 + 14 + 16 + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid_i = 1'b0;
    logic signed [15:0] smp_i = '0;
    logic [11:0]        ncyc_i = '0;
    logic               start_i = 1'b0;
    logic [1:0]         mode_i = '0;
    logic               rms_valid_i = 1'b0;
    logic [15:0]        rms_i = '0;
    logic               out_valid_o;
    logic signed [15:0] out_o;
    logic               busy_o, done_o, err_o;
    logic signed [15:0] offset_o;
    logic [15:0]        gain_o;

    cal_seq u0 (.*);

    always #5 clk = ~clk;

    int total = 0, fails = 0;
    bit cmp_en = 0;
    bit smp_en = 0, rms_en = 0;
    int lvl = 0, jit = 0, gap = 2, rms_val = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    // behavioural reference model
    int     m_ph, m_mode, m_n, m_cnt, m_wait, m_err, m_busy, m_done, m_ov;
    longint m_sum, m_rms, m_off, m_gain, m_out;

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint live(input longint s, input longint off, input longint g);
        return sat16((sat16(s + off) * g) >>> 14);
    endfunction

    task automatic model_write();
        longint q;
        if (m_mode == 0) begin
            q = -(m_sum / m_n);
            m_off = (q > 32767) ? 32767 : q;
        end else begin
            if (m_mode == 1) q = (m_sum <= 0) ? -1 : ((longint'(m_n) << 29) / m_sum);
            else             q = (m_rms == 0) ? -1 : (((64'd3 << 29) / 5) / m_rms);
            if (q < 0 || q > 65535) begin m_gain = 65535; m_err = 1; end
            else begin m_gain = q; m_err = 0; end
        end
    endtask

    always @(posedge clk) begin
        longint y;
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_n = 0; m_cnt = 0; m_wait = 0; m_err = 0;
            m_busy = 0; m_done = 0; m_ov = 0; m_sum = 0; m_rms = 0;
            m_off = 0; m_gain = 16384; m_out = 0;
        end else begin
            y = live(longint'(smp_i), m_off, m_gain);
            m_done = 0;
            case (m_ph)
                0: if (start_i && mode_i != 3 && ncyc_i != 0) begin
                    m_ph = 1; m_mode = int'(mode_i); m_n = int'(ncyc_i);
                    m_cnt = 0; m_sum = 0; m_rms = 0; m_err = 0;
                    if (mode_i != 0) m_gain = 16384;
                end
                1: if (smp_valid_i) begin
                    m_cnt++;
                    if (m_cnt == 30) begin m_ph = 2; m_cnt = 0; end
                end
                2: begin
                    if (m_mode == 2 && rms_valid_i) m_rms = longint'(rms_i);
                    if (smp_valid_i) begin
                        if (m_mode == 0) m_sum += longint'(smp_i);
                        else if (m_mode == 1) m_sum += y;
                        m_cnt++;
                        if (m_cnt == ((m_mode == 2) ? 6 * m_n : m_n)) begin
                            m_ph = 3; m_wait = LAT;
                        end
                    end
                end
                3: begin
                    m_wait--;
                    if (m_wait == 0) begin model_write(); m_done = 1; m_ph = 4; end
                end
                default: m_ph = 0;
            endcase
            if (smp_valid_i) m_out = y;
            m_ov = smp_valid_i;
            m_busy = (m_ph != 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk_eq("R1 out_valid", out_valid_o, m_ov);
            chk_eq("R1 out", out_o, m_out);
            chk_eq("R8 busy", busy_o, m_busy);
            chk_eq("R7 done", done_o, m_done);
            chk_eq("R9 err", err_o, m_err);
            chk_eq("R3 offset", offset_o, m_off);
            chk_eq("R5 gain", gain_o, m_gain);
        end
    end

    // sample and RMS drivers
    initial begin
        int ph = 0;
        bit tog = 0;
        forever begin
            @(negedge clk);
            if (smp_en && ph == 0) begin
                smp_valid_i = 1'b1;
                smp_i = 16'(tog ? lvl + jit : lvl - jit);
                tog = !tog;
            end else begin
                smp_valid_i = 1'b0;
            end
            ph = (ph + 1) % gap;
        end
    end

    initial begin
        int rc = 0;
        forever begin
            @(negedge clk);
            rc++;
            if (rms_en && rc % 16 == 0) begin
                rms_valid_i = 1'b1;
                rms_i = 16'(rms_val);
            end else begin
                rms_valid_i = 1'b0;
            end
        end
    end

    task automatic start_cal(input int md, input int n);
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(md); ncyc_i = 12'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int conv);
        int t = 0;
        conv = 0;
        forever begin
            @(posedge clk);
            if (smp_valid_i) conv++;
            @(negedge clk);
            if (done_o) break;
            t++;
            if (t > 20000) begin chk(0, "R7 done timeout", 0, 1); break; end
        end
    endtask

    task automatic wait_out(output longint v);
        int t = 0;
        do begin @(negedge clk); t++; end while (!out_valid_o && t < 100);
        v = out_o;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int conv;
        longint v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_eq("R2 reset offset", offset_o, 0);
        chk_eq("R2 reset gain", gain_o, 16384);
        chk_eq("R2 reset busy", busy_o, 0);
        chk_eq("R2 reset err", err_o, 0);
        chk_eq("R2 reset out_valid", out_valid_o, 0);
        chk_eq("R2 reset out", out_o, 0);
        cmp_en = 1;

        // pass-through at unity gain
        lvl = 1000; jit = 50; smp_en = 1;
        repeat (8) @(negedge clk);
        wait_out(v);
        chk(v == 950 || v == 1050, "R1 unity passthrough", v, 1000);

        // ignored starts
        start_cal(3, 16);
        chk_eq("R8 reserved mode ignored", busy_o, 0);
        start_cal(0, 0);
        chk_eq("R8 zero count ignored", busy_o, 0);

        // DC offset
        lvl = -300; jit = 40;
        start_cal(0, 16);
        chk_eq("R8 busy after start", busy_o, 1);
        wait_done(conv);
        chk(conv >= 16 + 30, "R7 DC duration", conv, 46);
        chk_eq("R3 offset result", offset_o, 300);

        // DC gain with an ignored start while busy
        lvl = 16084; jit = 20;
        start_cal(1, 16);
        repeat (20) @(negedge clk);
        start_i = 1'b1; mode_i = 2'd2;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(conv);
        chk_eq("R5 DC gain result", gain_o, 32768);
        chk_eq("R8 start while busy ignored (err)", err_o, 0);

        // saturation of the live path
        lvl = 20000; jit = 0;
        repeat (6) @(negedge clk);
        wait_out(v);
        chk_eq("R1 positive saturation", v, 32767);
        lvl = -20000;
        repeat (6) @(negedge clk);
        wait_out(v);
        chk_eq("R1 negative saturation", v, -32768);

        // AC gain, latest RMS in window used
        lvl = 3000; jit = 500;
        rms_val = 8000; rms_en = 1;
        start_cal(2, 16);
        chk_eq("R4 gain unity at start", gain_o, 16384);
        fork
            begin repeat (120) @(negedge clk); rms_val = 16384; end
            wait_done(conv);
        join
        chk(conv >= 6 * 16 + 30, "R7 AC duration", conv, 126);
        chk_eq("R6 AC gain result", gain_o, 19660);
        chk_eq("R6 AC no error", err_o, 0);

        // AC gain with no RMS strobe: zero divisor
        rms_en = 0;
        start_cal(2, 8);
        wait_done(conv);
        chk_eq("R9 zero rms gain", gain_o, 65535);
        chk_eq("R9 zero rms err", err_o, 1);

        // DC gain quotient overflow (offset 300, mean 0.25)
        lvl = 7892; jit = 30;
        start_cal(1, 16);
        wait_done(conv);
        chk_eq("R9 overflow gain", gain_o, 65535);
        chk_eq("R9 overflow err", err_o, 1);

        // err clears on next accepted start
        start_cal(0, 4);
        chk_eq("R9 err cleared", err_o, 0);
        wait_done(conv);
        chk_eq("R3 offset second run", offset_o, -7892);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule